// File: doc/BRIEF.md
# Exclusive access reservation monitor

This block arbitrates locked loads and conditional stores from several requesters that share one memory. Each requester may, in any cycle, present a locked load, a conditional store or a plain store. It also has an input that signals that the requester has just taken an interrupt. For each requester the monitor keeps one reservation: a valid flag and the index of a 16-byte granule. A conditional store commits to memory only while its issuer's reservation is intact. The reservation is broken by any write from another requester into that granule, by an interrupt, or by a newer locked load. Because the monitor tracks writes and not values, a location that is written away and then written back still breaks the reservation.

All requests of a cycle are resolved together. Each request gets a registered response one cycle later, carrying read data and a status bit that is 0 on success and 1 on failure. A small register-file memory inside the block stands in for the shared memory.

Top module: `excl_mon_top`

## Requirements
- R1: A locked load (op code 1) returns the 32-bit memory word at its address, ignoring byte-offset bits [1:0]. The response comes one cycle after the request, with status 0, and the load starts a reservation on granule addr[7:4].
- R2: A conditional store (op code 2) whose issuer holds a reservation on the addressed granule, with no break and no interrupt, writes its data to the addressed word and returns status 0.
- R3: A failed conditional store returns status 1 and leaves memory unchanged.
- R4: A write by another requester to any word of the reserved 16-byte granule breaks the reservation, including a write in the same cycle as the locked load. A write outside the granule leaves it intact.
- R5: Writing a different value and then the original value back still breaks the reservation.
- R6: An interrupt-taken pulse clears only that requester's reservation. An interrupt in the same cycle as a conditional store fails the store, and an interrupt in the same cycle as a locked load leaves no reservation.
- R7: A conditional store without an active reservation fails, and every conditional store clears its issuer's reservation.
- R8: A new locked load replaces the requester's previous reservation.
- R9: When requesters with reservations on one granule issue conditional stores in the same cycle, the lowest-numbered one succeeds and the others fail.
- R10: A successful conditional store clears the reservations that other requesters hold on that granule.
- R11: A plain store (op code 3) always writes and returns status 0, and a requester's own plain store does not break its reservation. A plain store by another requester to the granule in the same cycle fails the conditional store. When plain stores hit one word in one cycle, the lowest-numbered requester's data is kept.
- R12: After reset no response is valid, memory reads zero and no reservation exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | N_REQ | Request present, one bit per requester |
| req_op_i | input | 2*N_REQ | Op code per requester: 0 idle, 1 locked load, 2 conditional store, 3 plain store |
| req_addr_i | input | ADDR_W*N_REQ | Byte address per requester |
| req_wdata_i | input | DATA_W*N_REQ | Store data per requester |
| irq_taken_i | input | N_REQ | Interrupt taken by requester |
| rsp_valid_o | output | N_REQ | Response valid, one cycle after request |
| rsp_rdata_o | output | DATA_W*N_REQ | Locked-load data, zero otherwise |
| rsp_status_o | output | N_REQ | 0 success, 1 conditional store failed |

## Verification
The bench uses the defaults: four requesters, 8-bit byte addresses, 32-bit words and a 16-byte granule. With four requesters it can have two of them contend for one granule while a third writes elsewhere and the fourth acts as an observer. The observer reads memory back through locked loads that never feed a conditional store. Four words per granule let the bench hit the same granule through a different word and a different byte offset, and break a reservation with a write to a neighbouring word.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_LDL  = 2'd1,
    OP_STC  = 2'd2,
    OP_ST   = 2'd3
  } op_e;
endpackage

// File: rtl/excl_mon_mem.sv
module excl_mon_mem #(
  parameter int N_REQ  = 4,
  parameter int DATA_W = 32,
  parameter int IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i   [N_REQ],
  input  logic [IDX_W-1:0]  wr_idx_i  [N_REQ],
  input  logic [DATA_W-1:0] wr_data_i [N_REQ],
  input  logic [IDX_W-1:0]  rd_idx_i  [N_REQ],
  output logic [DATA_W-1:0] rd_data_o [N_REQ]
);
  localparam int WORDS = 2 ** IDX_W;

  logic [DATA_W-1:0] mem_q [WORDS];

  // lower index is applied last so it wins on a shared word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int w = 0; w < WORDS; w++) mem_q[w] <= '0;
    end else begin
      for (int j = N_REQ - 1; j >= 0; j--) begin
        if (wr_en_i[j]) mem_q[wr_idx_i[j]] <= wr_data_i[j];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N_REQ; i++) rd_data_o[i] = mem_q[rd_idx_i[i]];
  end

  AST_PORT0_LANDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i[0] |=> mem_q[$past(wr_idx_i[0])] == $past(wr_data_i[0])); // R11
endmodule

// File: rtl/excl_mon_arb.sv
module excl_mon_arb
  import excl_mon_pkg::*;
#(
  parameter int N_REQ  = 4,
  parameter int GRAN_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i      [N_REQ],
  input  op_e               op_i         [N_REQ],
  input  logic [GRAN_W-1:0] gran_i       [N_REQ],
  input  logic              irq_i        [N_REQ],
  input  logic              resv_valid_i [N_REQ],
  input  logic [GRAN_W-1:0] resv_gran_i  [N_REQ],
  output logic              stc_ok_o     [N_REQ],
  output logic              wr_en_o      [N_REQ]
);
  logic is_st  [N_REQ];
  logic is_stc [N_REQ];
  logic cand   [N_REQ];

  always_comb begin
    for (int i = 0; i < N_REQ; i++) begin
      is_st[i]  = valid_i[i] && (op_i[i] == OP_ST);
      is_stc[i] = valid_i[i] && (op_i[i] == OP_STC);
    end
    // candidate: own reservation intact, no plain store into the granule this cycle
    for (int i = 0; i < N_REQ; i++) begin
      cand[i] = is_stc[i] && resv_valid_i[i] && (resv_gran_i[i] == gran_i[i]) && !irq_i[i];
      for (int j = 0; j < N_REQ; j++) begin
        if (j != i && is_st[j] && gran_i[j] == gran_i[i]) cand[i] = 1'b0;
      end
    end
    // fixed priority among candidates on one granule
    for (int i = 0; i < N_REQ; i++) begin
      stc_ok_o[i] = cand[i];
      for (int j = 0; j < i; j++) begin
        if (cand[j] && gran_i[j] == gran_i[i]) stc_ok_o[i] = 1'b0;
      end
      wr_en_o[i] = is_st[i] || stc_ok_o[i];
    end
  end

  for (genvar g = 0; g < N_REQ; g++) begin : g_chk
    AST_OK_NEEDS_RESV: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stc_ok_o[g] |-> (resv_valid_i[g] && !irq_i[g])); // R7
    if (g > 0) begin : g_pri
      AST_LOW_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stc_ok_o[g] && stc_ok_o[0]) |-> (gran_i[g] != gran_i[0])); // R9
    end
  end
endmodule

// File: rtl/excl_mon_resv.sv
module excl_mon_resv #(
  parameter int N_REQ  = 4,
  parameter int GRAN_W = 4,
  parameter int IDX    = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              is_ldl_i,
  input  logic              is_stc_i,
  input  logic              irq_i,
  input  logic [GRAN_W-1:0] req_gran_i,
  input  logic              wr_en_i   [N_REQ],
  input  logic [GRAN_W-1:0] wr_gran_i [N_REQ],
  output logic              valid_o,
  output logic [GRAN_W-1:0] gran_o
);
  logic              valid_q, valid_d, hit;
  logic [GRAN_W-1:0] gran_q, gran_d;

  always_comb begin
    gran_d  = is_ldl_i ? req_gran_i : gran_q;
    valid_d = is_ldl_i ? 1'b1 : (is_stc_i ? 1'b0 : valid_q);
    hit     = 1'b0;
    // foreign writes of this cycle also kill a reservation taken in this cycle
    for (int j = 0; j < N_REQ; j++) begin
      if (j != IDX && wr_en_i[j] && wr_gran_i[j] == gran_d) hit = 1'b1;
    end
    if (hit || irq_i) valid_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      gran_q  <= '0;
    end else begin
      valid_q <= valid_d;
      gran_q  <= gran_d;
    end
  end

  assign valid_o = valid_q;
  assign gran_o  = gran_q;

  AST_IRQ_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !valid_q); // R6
  AST_STC_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (is_stc_i && !is_ldl_i) |=> !valid_q); // R7
  AST_LDL_GRAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    is_ldl_i |=> gran_q == $past(req_gran_i)); // R8
endmodule

// File: rtl/excl_mon_top.sv
module excl_mon_top
  import excl_mon_pkg::*;
#(
  parameter int N_REQ      = 4,
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 32,
  parameter int GRAN_BYTES = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_REQ-1:0]        req_valid_i,
  input  logic [2*N_REQ-1:0]      req_op_i,
  input  logic [ADDR_W*N_REQ-1:0] req_addr_i,
  input  logic [DATA_W*N_REQ-1:0] req_wdata_i,
  input  logic [N_REQ-1:0]        irq_taken_i,
  output logic [N_REQ-1:0]        rsp_valid_o,
  output logic [DATA_W*N_REQ-1:0] rsp_rdata_o,
  output logic [N_REQ-1:0]        rsp_status_o
);
  localparam int WORD_LSB = $clog2(DATA_W / 8);
  localparam int GRAN_LSB = $clog2(GRAN_BYTES);
  localparam int IDX_W    = ADDR_W - WORD_LSB;
  localparam int GRAN_W   = ADDR_W - GRAN_LSB;

  logic              valid      [N_REQ];
  op_e               op         [N_REQ];
  logic              irq        [N_REQ];
  logic [IDX_W-1:0]  idx        [N_REQ];
  logic [GRAN_W-1:0] gran       [N_REQ];
  logic [DATA_W-1:0] wdata      [N_REQ];
  logic [DATA_W-1:0] rdata      [N_REQ];
  logic              resv_valid [N_REQ];
  logic [GRAN_W-1:0] resv_gran  [N_REQ];
  logic              stc_ok     [N_REQ];
  logic              wr_en      [N_REQ];

  for (genvar g = 0; g < N_REQ; g++) begin : g_lane
    logic [ADDR_W-1:0] addr;
    logic              is_ldl, is_stc;

    assign addr     = req_addr_i[g*ADDR_W +: ADDR_W];
    assign valid[g] = req_valid_i[g];
    assign op[g]    = op_e'(req_op_i[g*2 +: 2]);
    assign irq[g]   = irq_taken_i[g];
    assign idx[g]   = addr[ADDR_W-1:WORD_LSB];
    assign gran[g]  = addr[ADDR_W-1:GRAN_LSB];
    assign wdata[g] = req_wdata_i[g*DATA_W +: DATA_W];
    assign is_ldl   = valid[g] && (op[g] == OP_LDL);
    assign is_stc   = valid[g] && (op[g] == OP_STC);

    excl_mon_resv #(.N_REQ(N_REQ), .GRAN_W(GRAN_W), .IDX(g)) u_resv (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .is_ldl_i   (is_ldl),
      .is_stc_i   (is_stc),
      .irq_i      (irq[g]),
      .req_gran_i (gran[g]),
      .wr_en_i    (wr_en),
      .wr_gran_i  (gran),
      .valid_o    (resv_valid[g]),
      .gran_o     (resv_gran[g])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        rsp_valid_o[g]                 <= 1'b0;
        rsp_status_o[g]                <= 1'b0;
        rsp_rdata_o[g*DATA_W +: DATA_W] <= '0;
      end else begin
        rsp_valid_o[g]                 <= valid[g];
        rsp_status_o[g]                <= is_stc && !stc_ok[g];
        rsp_rdata_o[g*DATA_W +: DATA_W] <= is_ldl ? rdata[g] : '0;
      end
    end

    AST_RSP_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid[g] |=> rsp_valid_o[g]); // R1
    AST_NORESV_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_stc && !resv_valid[g]) |=> rsp_status_o[g]); // R7
    AST_IRQ_STC_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (is_stc && irq[g]) |=> rsp_status_o[g]); // R6
  end

  excl_mon_arb #(.N_REQ(N_REQ), .GRAN_W(GRAN_W)) u_arb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .valid_i      (valid),
    .op_i         (op),
    .gran_i       (gran),
    .irq_i        (irq),
    .resv_valid_i (resv_valid),
    .resv_gran_i  (resv_gran),
    .stc_ok_o     (stc_ok),
    .wr_en_o      (wr_en)
  );

  excl_mon_mem #(.N_REQ(N_REQ), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en),
    .wr_idx_i  (idx),
    .wr_data_i (wdata),
    .rd_idx_i  (idx),
    .rd_data_o (rdata)
  );
endmodule

// File: tb/excl_mon_top_bench.sv
module excl_mon_top_bench;
  localparam int N  = 4;
  localparam int AW = 8;
  localparam int DW = 32;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req_valid = '0;
  logic [2*N-1:0]  req_op = '0;
  logic [AW*N-1:0] req_addr = '0;
  logic [DW*N-1:0] req_wdata = '0;
  logic [N-1:0]    irq = '0;
  logic [N-1:0]    rsp_valid;
  logic [DW*N-1:0] rsp_rdata;
  logic [N-1:0]    rsp_status;

  int n_cmp = 0;
  int n_bad = 0;

  logic [DW:0] exp_q [N][$];
  string       tag_q [N][$];

  always #2 clk = ~clk;

  excl_mon_top #(.N_REQ(N), .ADDR_W(AW), .DATA_W(DW), .GRAN_BYTES(16)) u_excl_mon_top (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .req_valid_i  (req_valid),
    .req_op_i     (req_op),
    .req_addr_i   (req_addr),
    .req_wdata_i  (req_wdata),
    .irq_taken_i  (irq),
    .rsp_valid_o  (rsp_valid),
    .rsp_rdata_o  (rsp_rdata),
    .rsp_status_o (rsp_status)
  );

  task automatic put(input int i, input logic [1:0] op, input logic [7:0] addr,
                     input logic [31:0] data, input logic [31:0] erd, input logic est,
                     input string tag);
    req_valid[i]          = 1'b1;
    req_op[i*2 +: 2]      = op;
    req_addr[i*AW +: AW]  = addr;
    req_wdata[i*DW +: DW] = data;
    exp_q[i].push_back({est, erd});
    tag_q[i].push_back(tag);
  endtask

  task automatic go();
    @(posedge clk);
    @(negedge clk);
    req_valid = '0;
    req_op    = '0;
    req_addr  = '0;
    req_wdata = '0;
    irq       = '0;
  endtask

  // op helpers
  task automatic ldl(input int i, input logic [7:0] a, input logic [31:0] e, input string t);
    put(i, 2'd1, a, 32'd0, e, 1'b0, t);
  endtask
  task automatic stc(input int i, input logic [7:0] a, input logic [31:0] d, input logic est, input string t);
    put(i, 2'd2, a, d, 32'd0, est, t);
  endtask
  task automatic st(input int i, input logic [7:0] a, input logic [31:0] d, input string t);
    put(i, 2'd3, a, d, 32'd0, 1'b0, t);
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n) begin
      for (int i = 0; i < N; i++) begin
        if (rsp_valid[i]) begin
          n_cmp++;
          if (exp_q[i].size() == 0) begin
            n_bad++;
            $display("FAIL R1 lane %0d unexpected response act=%0b exp=0", i, rsp_valid[i]);
          end else begin
            logic [DW:0] e;
            string       t;
            e = exp_q[i].pop_front();
            t = tag_q[i].pop_front();
            if (rsp_status[i] !== e[DW] || rsp_rdata[i*DW +: DW] !== e[DW-1:0]) begin
              n_bad++;
              $display("FAIL %s lane %0d act=%0b/%h exp=%0b/%h", t, i,
                       rsp_status[i], rsp_rdata[i*DW +: DW], e[DW], e[DW-1:0]);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog act=running exp=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if (rsp_valid !== '0) begin
      n_bad++;
      $display("FAIL R12 rsp_valid in reset act=%b exp=0", rsp_valid);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R12 no reservation after reset, memory zero
    stc(0, 8'h10, 32'h1, 1'b1, "R12"); go();
    ldl(3, 8'h10, 32'h0, "R12"); go();

    // R11 plain store, R1 locked load with byte offset
    st(0, 8'h10, 32'hAAAA0001, "R11"); go();
    ldl(3, 8'h10, 32'hAAAA0001, "R1"); go();
    ldl(3, 8'h13, 32'hAAAA0001, "R1"); go();

    // R2 success to another word of the granule
    ldl(0, 8'h20, 32'h0, "R1"); go();
    stc(0, 8'h24, 32'h11, 1'b0, "R2"); go();
    ldl(3, 8'h24, 32'h11, "R2"); go();
    // R7 second store without reservation, R3 memory untouched
    stc(0, 8'h24, 32'h99, 1'b1, "R7"); go();
    ldl(3, 8'h24, 32'h11, "R3"); go();

    // R4 neighbour word write in granule breaks
    ldl(1, 8'h30, 32'h0, "R4"); go();
    st(2, 8'h3C, 32'h5, "R4"); go();
    stc(1, 8'h30, 32'h7, 1'b1, "R4"); go();
    ldl(3, 8'h30, 32'h0, "R3"); go();
    // R4 write outside granule keeps it
    ldl(1, 8'h30, 32'h0, "R4"); go();
    st(2, 8'h40, 32'h9, "R4"); go();
    stc(1, 8'h30, 32'h7, 1'b0, "R4"); go();
    ldl(3, 8'h30, 32'h7, "R4"); go();
    // R4 write in same cycle as locked load
    ldl(0, 8'hE0, 32'h0, "R4"); st(1, 8'hE4, 32'h9, "R4"); go();
    stc(0, 8'hE0, 32'h1, 1'b1, "R4"); go();

    // R5 A-B-A
    ldl(0, 8'h50, 32'h0, "R5"); go();
    st(1, 8'h50, 32'h1, "R5"); go();
    st(1, 8'h50, 32'h0, "R5"); go();
    stc(0, 8'h50, 32'h22, 1'b1, "R5"); go();
    ldl(3, 8'h50, 32'h0, "R5"); go();

    // R6 interrupts
    ldl(0, 8'h60, 32'h0, "R6"); go();
    irq[0] = 1'b1; go();
    stc(0, 8'h60, 32'h1, 1'b1, "R6"); go();
    ldl(0, 8'h60, 32'h0, "R6"); go();
    stc(0, 8'h60, 32'h2, 1'b1, "R6"); irq[0] = 1'b1; go();
    ldl(0, 8'h60, 32'h0, "R6"); irq[0] = 1'b1; go();
    stc(0, 8'h60, 32'h3, 1'b1, "R6"); go();
    ldl(3, 8'h60, 32'h0, "R6"); go();
    ldl(0, 8'h60, 32'h0, "R6"); go();
    irq[1] = 1'b1; go();
    stc(0, 8'h60, 32'h33, 1'b0, "R6"); go();
    ldl(3, 8'h60, 32'h33, "R6"); go();

    // R8 replacement
    ldl(0, 8'h70, 32'h0, "R8"); go();
    ldl(0, 8'h80, 32'h0, "R8"); go();
    stc(0, 8'h70, 32'h1, 1'b1, "R8"); go();
    ldl(0, 8'h70, 32'h0, "R8"); go();
    ldl(0, 8'h80, 32'h0, "R8"); go();
    stc(0, 8'h80, 32'h44, 1'b0, "R8"); go();
    ldl(3, 8'h80, 32'h44, "R8"); go();

    // R9 same-cycle contention
    ldl(1, 8'h90, 32'h0, "R9"); ldl(2, 8'h94, 32'h0, "R9"); go();
    stc(1, 8'h90, 32'h55, 1'b0, "R9"); stc(2, 8'h94, 32'h66, 1'b1, "R9"); go();
    ldl(3, 8'h90, 32'h55, "R9"); go();
    ldl(3, 8'h94, 32'h0, "R9"); go();

    // R10 winner clears the other reservation
    ldl(0, 8'hA0, 32'h0, "R10"); ldl(1, 8'hA0, 32'h0, "R10"); go();
    stc(0, 8'hA0, 32'h77, 1'b0, "R10"); go();
    stc(1, 8'hA0, 32'h88, 1'b1, "R10"); go();
    ldl(3, 8'hA0, 32'h77, "R10"); go();

    // R11 own store keeps reservation
    ldl(0, 8'hB0, 32'h0, "R11"); go();
    st(0, 8'hB4, 32'h1, "R11"); go();
    stc(0, 8'hB0, 32'h2, 1'b0, "R11"); go();
    // R11 same-cycle foreign plain store fails the conditional store
    ldl(1, 8'hC0, 32'h0, "R11"); go();
    stc(1, 8'hC0, 32'h3, 1'b1, "R11"); st(2, 8'hC8, 32'h4, "R11"); go();
    ldl(3, 8'hC0, 32'h0, "R11"); go();
    ldl(3, 8'hC8, 32'h4, "R11"); go();
    // R11 store collision
    st(1, 8'hD0, 32'h5, "R11"); st(2, 8'hD0, 32'h6, "R11"); go();
    ldl(3, 8'hD0, 32'h5, "R11"); go();

    repeat (3) @(negedge clk);
    for (int i = 0; i < N; i++) begin
      n_cmp++;
      if (exp_q[i].size() != 0) begin
        n_bad++;
        $display("FAIL R1 lane %0d missing responses act=%0d exp=0", i, exp_q[i].size());
      end
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule